// File: doc/BRIEF.md
# UART Oversampling Tick Generator with Staged Divisor

This block derives the 16x oversampling tick shared by a UART transmitter and receiver from a 7.3728 MHz reference clock. A 16-bit divisor D sets the rate. Over every run of 16 + D reference clocks the block emits exactly 16 one-clock tick pulses, so the baud rate is 7.3728 MHz / (16 + D). A fractional accumulator spreads these pulses as evenly as whole clocks allow. D = 0 yields a tick on every clock.

Software writes the divisor one byte at a time through a byte write port. A write to the low-byte address only stages that byte in a shadow register, and the running rate does not change. A write to the high-byte address commits the new high byte and the staged low byte together, in one clock. The commit also restarts the tick accumulator, so no period mixes the old and new rates. If no low-byte write came before a high-byte write, the commit reuses whatever low byte is already staged. After reset the divisor is 0x02F0, which gives 9600 baud.

Top module: `baud_divisor_top`

## Requirements
- R1: After reset, active_div reads 0x02F0, staged_lo reads 0xF0 and tick is low. The first 768 clocks after reset is released contain exactly 16 ticks.
- R2: A write with wr_addr = 0 (low byte) loads wr_data into staged_lo by the next clock and leaves active_div unchanged.
- R3: A write with wr_addr = 1 (high byte) sets active_div to {wr_data, staged_lo} by the next clock.
- R4: A high-byte write with no low-byte write since the previous commit uses the low byte already staged.
- R5: A commit restarts the accumulator. With P = 16 + D, tick is low in the clock after the commit edge, and the first tick comes ceil(P/16) clocks after the commit edge.
- R6: The first P clocks after a commit contain exactly 16 ticks.
- R7: Two consecutive ticks are never more than ceil(P/16) clocks apart and never fewer than floor(P/16) clocks apart.
- R8: With D = 0, tick is high on every clock after the commit.
- R9: While wr_en is low, neither active_div nor staged_lo changes, whatever is driven on wr_addr and wr_data.
- R10: When P is a multiple of 16, ticks are exactly P/16 clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 7.3728 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 1 | 0 selects the low divisor byte, 1 selects the high byte and commits |
| wr_data | input | 8 | Byte to write |
| tick | output | 1 | One-clock 16x oversampling tick |
| active_div | output | 16 | Divisor currently setting the rate |
| staged_lo | output | 8 | Low byte waiting in the shadow register |

## Verification
The divisor is tried at D = 0, 1, 24, 48 and the reset value 752. D = 0 shows that a tick can come on every clock. D = 1 and D = 24 force uneven spacing, which shows whether the accumulator keeps its remainder. D = 48 and D = 752 are multiples of 16 and must give perfectly regular ticks, which catches an off-by-one in the period. Commits arrive while the previous rate is running and with the low-byte write both present and absent, so the bench can tell a true restart and a correct byte pairing from leftover state.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    localparam int unsigned OSR    = 16;
    localparam int unsigned OSR_SH = $clog2(OSR);
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DIV_W  = 2 * BYTE_W;
    localparam int unsigned PER_W  = DIV_W + 1;
    localparam int unsigned ACC_W  = PER_W + 1;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } div_t;

    typedef struct packed {
        logic              valid;
        reg_sel_e          sel;
        logic [BYTE_W-1:0] data;
    } wr_t;

    function automatic logic [PER_W-1:0] period_of(input div_t d);
        return {1'b0, d} + PER_W'(OSR);
    endfunction

endpackage

// File: rtl/baud_divreg.sv
module baud_divreg
    import baudgen_pkg::*;
#(
    parameter div_t RST_DIV = 16'h02F0
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_t               wr,
    output div_t              active,
    output logic [BYTE_W-1:0] staged,
    output logic              commit
);

    assign commit = wr.valid && (wr.sel == SEL_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= RST_DIV;
            staged <= RST_DIV.lo;
        end else if (wr.valid) begin
            if (wr.sel == SEL_LO) begin
                staged <= wr.data;
            end else begin
                active <= '{hi: wr.data, lo: staged};
            end
        end
    end

    // R2: a low-byte write lands in the shadow only
    assert_lo_stage_R2: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.sel == SEL_LO) |=> (staged == $past(wr.data)) && $stable(active));

    // R3 / R4: a high-byte write pairs new high byte with the staged low byte
    assert_commit_pair_R3: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.sel == SEL_HI) |=> (active == {$past(wr.data), $past(staged)}));

    // R9: no strobe, no change
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr.valid |=> $stable(active) && $stable(staged));

endmodule

// File: rtl/baud_tick_acc.sv
module baud_tick_acc
    import baudgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    output logic             tick
);

    logic [PER_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             fire;

    assign sum  = {1'b0, acc_q} + ACC_W'(OSR);
    assign fire = sum >= {1'b0, period};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick  <= fire;
            acc_q <= fire ? PER_W'(sum - {1'b0, period}) : PER_W'(sum);
        end
    end

    // Spacing monitor: clocks since the last tick or restart
    logic [PER_W-1:0] gap_q;
    logic [ACC_W-1:0] gap_ceil;
    logic [ACC_W-1:0] gap_floor;
    logic             seen_q;

    assign gap_ceil  = ({1'b0, period} + ACC_W'(OSR - 1)) >> OSR_SH;
    assign gap_floor = {1'b0, period} >> OSR_SH;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            gap_q  <= tick ? PER_W'(1) : gap_q + PER_W'(1);
            seen_q <= seen_q | tick;
        end
    end

    // R5: the clock after a restart carries no tick
    assert_restart_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);

    // R6: remainder always below the period
    assert_acc_bound_R6: assert property (@(posedge clk) disable iff (rst)
        acc_q < period);

    // R7: upper spacing bound
    assert_gap_max_R7: assert property (@(posedge clk) disable iff (rst)
        tick |-> ({1'b0, gap_q} <= gap_ceil));

    // R7: lower spacing bound between two ticks
    assert_gap_min_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && seen_q) |-> ({1'b0, gap_q} >= gap_floor));

endmodule

// File: rtl/baud_divisor_top.sv
module baud_divisor_top
    import baudgen_pkg::*;
#(
    parameter logic [15:0] RST_DIV = 16'h02F0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [7:0]  wr_data,
    output logic        tick,
    output logic [15:0] active_div,
    output logic [7:0]  staged_lo
);

    wr_t              wr;
    div_t             active;
    logic             commit;
    logic [PER_W-1:0] period;

    assign wr.valid = wr_en;
    assign wr.sel   = reg_sel_e'(wr_addr);
    assign wr.data  = wr_data;

    baud_divreg #(
        .RST_DIV (div_t'(RST_DIV))
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .active (active),
        .staged (staged_lo),
        .commit (commit)
    );

    assign period     = period_of(active);
    assign active_div = active;

    baud_tick_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .restart (commit),
        .period  (period),
        .tick    (tick)
    );

    // R8: a zero divisor ticks on every clock once running
    assert_every_clock_R8: assert property (@(posedge clk) disable iff (rst)
        (active == '0 && !commit && $past(active) == '0 && !$past(commit)) |=> tick);

endmodule

// File: tb/baud_divisor_top_tb.sv
`timescale 1ns/1ps
module baud_divisor_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick;
    logic [15:0] active_div;
    logic [7:0]  staged_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    baud_divisor_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tick       (tick),
        .active_div (active_div),
        .staged_lo  (staged_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic wr_byte(input bit a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Watches per clocks right after a commit (or reset release).
    task automatic observe(input string tag, input int per, input bit exact_gap);
        int first = 0;
        int cnt   = 0;
        int last  = 0;
        int gmin  = 1 << 30;
        int gmax  = 0;
        for (int n = 1; n <= per; n++) begin
            @(negedge clk);
            if (tick) begin
                cnt++;
                if (first == 0) first = n;
                else begin
                    if (n - last < gmin) gmin = n - last;
                    if (n - last > gmax) gmax = n - last;
                end
                last = n;
            end
        end
        chk({"R5 first tick ", tag}, first, (per + 15) / 16);
        chk({"R6 tick count ", tag}, cnt, 16);
        chk({"R7 max gap ok ", tag}, int'(gmax <= (per + 15) / 16), 1);
        chk({"R7 min gap ok ", tag}, int'(gmin >= per / 16), 1);
        if (exact_gap) begin
            chk({"R10 min gap ", tag}, gmin, per / 16);
            chk({"R10 max gap ", tag}, gmax, per / 16);
        end
    endtask

    task automatic test_reset();
        chk("R1 active_div at reset", active_div, 16'h02F0);
        chk("R1 staged_lo at reset", staged_lo, 8'hF0);
        chk("R1 tick low at reset", tick, 0);
        rst = 1'b0;
        observe("R1 default 768", 768, 1'b1);
    endtask

    task automatic test_low_stage();
        wr_byte(1'b0, 8'h18);
        chk("R2 staged_lo loaded", staged_lo, 8'h18);
        chk("R2 active_div unchanged", active_div, 16'h02F0);
    endtask

    task automatic test_commit();
        wr_byte(1'b1, 8'h00);
        chk("R3 active_div committed", active_div, 16'h0018);
        chk("R5 tick low after commit", tick, 0);
        observe("P=40", 40, 1'b0);
        observe("P=40 second window", 40, 1'b0);
    endtask

    task automatic test_no_low();
        @(negedge clk);
        wr_byte(1'b1, 8'h01);
        chk("R4 reuse staged low", active_div, 16'h0118);
        wr_byte(1'b1, 8'h00);
        chk("R4 reuse staged low again", active_div, 16'h0018);
        observe("R4 P=40", 40, 1'b0);
    endtask

    task automatic test_idle();
        wr_en = 1'b0; wr_addr = 1'b1; wr_data = 8'h55;
        @(negedge clk);
        wr_addr = 1'b0; wr_data = 8'hAA;
        @(negedge clk);
        chk("R9 active_div ignored", active_div, 16'h0018);
        chk("R9 staged_lo ignored", staged_lo, 8'h18);
    endtask

    task automatic test_zero();
        int hi = 0;
        wr_byte(1'b0, 8'h00);
        wr_byte(1'b1, 8'h00);
        chk("R3 zero divisor", active_div, 0);
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (tick) hi++;
        end
        chk("R8 tick every clock", hi, 20);
    endtask

    task automatic test_seventeen();
        wr_byte(1'b0, 8'h01);
        wr_byte(1'b1, 8'h00);
        observe("P=17", 17, 1'b0);
    endtask

    task automatic test_sixtyfour();
        wr_byte(1'b0, 8'h30);
        wr_byte(1'b1, 8'h00);
        chk("R3 active 0x0030", active_div, 16'h0030);
        observe("R10 P=64", 64, 1'b1);
        repeat (7) @(negedge clk);
        wr_byte(1'b1, 8'h00);
        observe("R5 mid-period recommit P=64", 64, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_low_stage();
        test_commit();
        test_no_low();
        test_idle();
        test_zero();
        test_seventeen();
        test_sixtyfour();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule